// File: doc/BRIEF.md
# Scaled Min-Sum Soft Decoder for a Seven-Bit Parity-Check Code

This block decodes a seven-bit block protected by three parity checks. It takes one signed reliability value per bit (log-likelihood ratio, positive favouring 0, negative favouring 1). It refines these values by passing messages back and forth between the bits and the checks of the code's graph. Every edge of the graph keeps its own check-to-bit message in a register. All edges are updated together once per clock, which is a flooding schedule: one clock is one full iteration.

A caller presents the seven values on `llr_in` and pulses `start`. The block goes busy and iterates. It stops as soon as the hard decisions satisfy all three checks, or when the iteration budget runs out. At that point it pulses `done` and holds the decoded bits, the a-posteriori values, a success flag and the number of iterations run until the next start.

Top module: `ldpc_minsum_dec`

## Requirements
- R1: After reset `busy`, `done` and `success` are 0, and `iter_count`, `bits_out` and `app_out` are all zero.
- R2: A `start` seen while idle captures `llr_in`, clears every check-to-bit message to zero and sets `busy` on the next cycle. A `start` seen while busy is ignored and does not change the result of the run in progress.
- R3: The graph is fixed. Check 0 covers bits {0,1,2,4}, check 1 covers bits {1,2,3,5} and check 2 covers bits {0,1,3,6}. Bit n occupies `llr_in[n*LLR_W +: LLR_W]`, `app_out[n*LLR_W +: LLR_W]` and `bits_out[n]`.
- R4: The message from a bit to a check is that bit's channel value plus every incoming check message except the one from that check, saturated to the signed LLR_W-bit range.
- R5: The message from a check to a bit has the sign that makes the parity of the signs of the other incoming messages even. Zero counts as positive. Its magnitude is the smallest magnitude among the other incoming messages, m, reduced to m - floor(m/4).
- R6: After each iteration the a-posteriori value of a bit is its channel value plus all of its new check messages, saturated to [-2^(LLR_W-1), 2^(LLR_W-1)-1]. Its hard decision is 1 exactly when that value is negative.
- R7: When the hard decisions of an iteration satisfy all three checks, the run ends after that iteration with `success` = 1.
- R8: When MAX_ITER iterations pass without satisfying all checks, the run ends with `success` = 0 and `iter_count` = MAX_ITER.
- R9: A run of N iterations keeps `busy` high for N cycles after the start cycle. `done` is then a one-cycle pulse with `iter_count` = N, and all result outputs hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode with the values on `llr_in` |
| llr_in | input | 7*LLR_W | Channel reliability per bit, two's complement |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| success | output | 1 | Final hard decisions satisfy every check |
| bits_out | output | 7 | Hard decisions, bit n at index n |
| app_out | output | 7*LLR_W | A-posteriori value per bit |
| iter_count | output | $clog2(MAX_ITER+1) | Iterations run in the last decode |

## Verification
The bench builds the block with LLR_W = 6 and MAX_ITER = 4. A small budget makes random noisy inputs run out of iterations often, so the give-up path and its count are reached alongside early exits after one or several iterations. Keeping the LLR width at 6 lets directed inputs sit at -32 and +31, where the saturating sums and the magnitude of the most negative value matter. Runs longer than one iteration also carry a second start mid-run with different values to confirm it is ignored.

// File: rtl/ldpc_pkg.sv
package ldpc_pkg;

    localparam int NBITS = 7;
    localparam int NCHK  = 3;

    // Row m, column n: bit n takes part in check m
    localparam logic [NCHK-1:0][NBITS-1:0] HMAT = {
        7'b1001011,   // check 2: bits 0,1,3,6
        7'b0101110,   // check 1: bits 1,2,3,5
        7'b0010111    // check 0: bits 0,1,2,4
    };

    typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

    function automatic logic [NCHK-1:0] col_mask(input int n);
        logic [NCHK-1:0] cm;
        for (int m = 0; m < NCHK; m++) begin
            cm[m] = HMAT[m][n];
        end
        return cm;
    endfunction

endpackage

// File: rtl/ldpc_bit_node.sv
module ldpc_bit_node
    import ldpc_pkg::*;
#(
    parameter int              W     = 6,
    parameter logic [NCHK-1:0] CMASK = '0
) (
    input  logic [W-1:0]            llr,
    input  logic [NCHK-1:0][W-1:0]  r_prev,
    input  logic [NCHK-1:0][W-1:0]  r_cur,
    output logic [NCHK-1:0][W-1:0]  q_out,
    output logic [W-1:0]            app_out
);
    localparam int SW = W + 3;
    localparam logic signed [SW-1:0] SMAX = SW'((2 ** (W - 1)) - 1);
    localparam logic signed [SW-1:0] SMIN = -SW'(2 ** (W - 1));

    function automatic logic signed [SW-1:0] sx(input logic [W-1:0] v);
        return $signed({{(SW - W){v[W-1]}}, v});
    endfunction

    function automatic logic [W-1:0] sat(input logic signed [SW-1:0] v);
        logic [W-1:0] res;
        if (v > SMAX)      res = SMAX[W-1:0];
        else if (v < SMIN) res = SMIN[W-1:0];
        else               res = v[W-1:0];
        return res;
    endfunction

    logic signed [SW-1:0] total_d;
    logic signed [SW-1:0] excl_d;

    always_comb begin
        total_d = sx(llr);
        for (int m = 0; m < NCHK; m++) begin
            if (CMASK[m]) total_d = total_d + sx(r_cur[m]);
        end
        app_out = sat(total_d);

        excl_d = '0;
        for (int m = 0; m < NCHK; m++) begin
            excl_d = sx(llr);
            for (int k = 0; k < NCHK; k++) begin
                if (CMASK[k] && (k != m)) excl_d = excl_d + sx(r_prev[k]);
            end
            q_out[m] = CMASK[m] ? sat(excl_d) : '0;
        end
    end

endmodule

// File: rtl/ldpc_check_node.sv
module ldpc_check_node
    import ldpc_pkg::*;
#(
    parameter int               W     = 6,
    parameter logic [NBITS-1:0] RMASK = '0
) (
    input  logic [NBITS-1:0][W-1:0] q_in,
    output logic [NBITS-1:0][W-1:0] r_out
);
    logic [NBITS-1:0][W-1:0] mag_d;
    logic [W-1:0]            min_d;
    logic [W-1:0]            scl_d;
    logic                    neg_d;

    always_comb begin
        for (int n = 0; n < NBITS; n++) begin
            mag_d[n] = q_in[n][W-1] ? (~q_in[n] + 1'b1) : q_in[n];
        end

        min_d = '1;
        scl_d = '0;
        neg_d = 1'b0;
        for (int n = 0; n < NBITS; n++) begin
            min_d = '1;
            neg_d = 1'b0;
            for (int k = 0; k < NBITS; k++) begin
                if (RMASK[k] && (k != n)) begin
                    neg_d = neg_d ^ q_in[k][W-1];
                    if (mag_d[k] < min_d) min_d = mag_d[k];
                end
            end
            scl_d    = min_d - (min_d >> 2);
            r_out[n] = RMASK[n] ? (neg_d ? (~scl_d + 1'b1) : scl_d) : '0;
        end
    end

endmodule

// File: rtl/ldpc_minsum_dec.sv
module ldpc_minsum_dec
    import ldpc_pkg::*;
#(
    parameter int LLR_W    = 6,
    parameter int MAX_ITER = 10,
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NBITS*LLR_W-1:0] llr_in,
    output logic                   busy,
    output logic                   done,
    output logic                   success,
    output logic [NBITS-1:0]       bits_out,
    output logic [NBITS*LLR_W-1:0] app_out,
    output logic [IW-1:0]          iter_count
);
    localparam int W = LLR_W;

    typedef struct packed {
        phase_e                            phase;
        logic [NBITS-1:0][W-1:0]           chan;
        logic [NCHK-1:0][NBITS-1:0][W-1:0] rmsg;
        logic [NBITS-1:0][W-1:0]           app;
        logic [NBITS-1:0]                  hard;
        logic [IW-1:0]                     iter;
        logic                              done;
        logic                              ok;
    } state_t;

    state_t s_q, s_d;

    logic [NBITS-1:0][NCHK-1:0][W-1:0] r_prev_col;
    logic [NBITS-1:0][NCHK-1:0][W-1:0] r_cur_col;
    logic [NBITS-1:0][NCHK-1:0][W-1:0] q_col;
    logic [NCHK-1:0][NBITS-1:0][W-1:0] q_row;
    logic [NCHK-1:0][NBITS-1:0][W-1:0] r_new;
    logic [NBITS-1:0][W-1:0]           app_w;
    logic [NBITS-1:0]                  hard_w;
    logic [NCHK-1:0]                   syn_w;
    logic [IW-1:0]                     iter_nx;

    for (genvar m = 0; m < NCHK; m++) begin : g_edge_row
        for (genvar n = 0; n < NBITS; n++) begin : g_edge_col
            assign r_prev_col[n][m] = s_q.rmsg[m][n];
            assign r_cur_col[n][m]  = r_new[m][n];
            assign q_row[m][n]      = q_col[n][m];
        end
    end

    for (genvar m = 0; m < NCHK; m++) begin : g_chk
        ldpc_check_node #(
            .W     (W),
            .RMASK (HMAT[m])
        ) i_check_node (
            .q_in  (q_row[m]),
            .r_out (r_new[m])
        );
        assign syn_w[m] = ^(hard_w & HMAT[m]);
    end

    for (genvar n = 0; n < NBITS; n++) begin : g_bit
        ldpc_bit_node #(
            .W     (W),
            .CMASK (col_mask(n))
        ) i_bit_node (
            .llr     (s_q.chan[n]),
            .r_prev  (r_prev_col[n]),
            .r_cur   (r_cur_col[n]),
            .q_out   (q_col[n]),
            .app_out (app_w[n])
        );
        assign hard_w[n] = app_w[n][W-1];
    end

    assign iter_nx = s_q.iter + 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_RUN;
                    s_d.chan  = llr_in;
                    s_d.rmsg  = '0;
                    s_d.iter  = '0;
                    s_d.ok    = 1'b0;
                end
            end
            PH_RUN: begin
                s_d.rmsg = r_new;
                s_d.app  = app_w;
                s_d.hard = hard_w;
                s_d.iter = iter_nx;
                if ((syn_w == '0) || (iter_nx == IW'(MAX_ITER))) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                    s_d.ok    = (syn_w == '0);
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = (s_q.phase == PH_RUN);
    assign done       = s_q.done;
    assign success    = s_q.ok;
    assign bits_out   = s_q.hard;
    assign app_out    = s_q.app;
    assign iter_count = s_q.iter;

endmodule

// File: rtl/ldpc_minsum_chk.sv
module ldpc_minsum_chk
    import ldpc_pkg::*;
#(
    parameter int LLR_W    = 6,
    parameter int MAX_ITER = 10,
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   success,
    input logic [NBITS-1:0]       bits_out,
    input logic [NBITS*LLR_W-1:0] app_out,
    input logic [IW-1:0]          iter_count
);
    logic [NCHK-1:0] out_syn;
    for (genvar m = 0; m < NCHK; m++) begin : g_syn
        assign out_syn[m] = ^(bits_out & HMAT[m]);
    end

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_PASS_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && success) |-> (out_syn == '0)); // R7

    AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !success) |-> (int'(iter_count) == MAX_ITER)); // R8

    AST_ITER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        int'(iter_count) <= MAX_ITER); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(bits_out) && $stable(app_out) && $stable(success))); // R9

    for (genvar n = 0; n < NBITS; n++) begin : g_sign
        AST_HARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> (bits_out[n] == app_out[n*LLR_W + LLR_W - 1])); // R6
    end

endmodule

bind ldpc_minsum_dec ldpc_minsum_chk #(
    .LLR_W    (LLR_W),
    .MAX_ITER (MAX_ITER)
) i_ldpc_minsum_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .success    (success),
    .bits_out   (bits_out),
    .app_out    (app_out),
    .iter_count (iter_count)
);

// File: tb/test_ldpc_minsum_dec.sv
module test_ldpc_minsum_dec;
    localparam int W     = 6;
    localparam int MAXIT = 4;
    localparam int NB    = 7;
    localparam int IW    = $clog2(MAXIT + 1);
    localparam int LMAX  = 31;
    localparam int LMIN  = -32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NB*W-1:0]   llr_in = '0;
    logic              busy, done, success;
    logic [NB-1:0]     bits_out;
    logic [NB*W-1:0]   app_out;
    logic [IW-1:0]     iter_count;

    ldpc_minsum_dec #(.LLR_W(W), .MAX_ITER(MAXIT)) i_ldpc_minsum_dec (
        .clk(clk), .rst_n(rst_n), .start(start), .llr_in(llr_in),
        .busy(busy), .done(done), .success(success), .bits_out(bits_out),
        .app_out(app_out), .iter_count(iter_count)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int hb[3][7] = '{'{1,1,1,0,1,0,0}, '{0,1,1,1,0,1,0}, '{1,1,0,1,0,0,1}};
    int vin[7];
    int e_app[7];
    int e_hard[7];
    int e_iter;
    int e_ok;
    int n_fail_runs = 0;
    int n_multi_runs = 0;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clip(input int v);
        if (v > LMAX) return LMAX;
        if (v < LMIN) return LMIN;
        return v;
    endfunction

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Behavioural reference: whole decode in zero time
    task automatic model_run();
        int r[3][7];
        int rn[3][7];
        int q[3][7];
        foreach (r[m, n]) r[m][n] = 0;
        e_ok = 0;
        e_iter = 0;
        for (int it = 1; it <= MAXIT; it++) begin
            for (int m = 0; m < 3; m++)
                for (int n = 0; n < 7; n++) begin
                    int acc = vin[n];
                    for (int k = 0; k < 3; k++)
                        if (hb[k][n] == 1 && k != m) acc += r[k][n];
                    q[m][n] = clip(acc);
                end
            for (int m = 0; m < 3; m++)
                for (int n = 0; n < 7; n++) begin
                    int mn = 1000;
                    int neg = 0;
                    rn[m][n] = 0;
                    if (hb[m][n] == 1) begin
                        for (int k = 0; k < 7; k++)
                            if (hb[m][k] == 1 && k != n) begin
                                if (q[m][k] < 0) neg = 1 - neg;
                                if (absv(q[m][k]) < mn) mn = absv(q[m][k]);
                            end
                        mn = mn - (mn / 4);
                        rn[m][n] = neg ? -mn : mn;
                    end
                end
            for (int n = 0; n < 7; n++) begin
                int acc = vin[n];
                for (int m = 0; m < 3; m++) if (hb[m][n] == 1) acc += rn[m][n];
                e_app[n] = clip(acc);
                e_hard[n] = (e_app[n] < 0) ? 1 : 0;
            end
            r = rn;
            e_iter = it;
            begin
                int bad = 0;
                for (int m = 0; m < 3; m++) begin
                    int p = 0;
                    for (int n = 0; n < 7; n++) if (hb[m][n] == 1) p ^= e_hard[n];
                    bad |= p;
                end
                if (bad == 0) begin
                    e_ok = 1;
                    break;
                end
            end
        end
    endtask

    function automatic logic [NB*W-1:0] pack(input int v[7]);
        logic [NB*W-1:0] p;
        for (int n = 0; n < 7; n++) p[n*W +: W] = W'(v[n]);
        return p;
    endfunction

    task automatic check_results(input string tag);
        for (int n = 0; n < 7; n++) begin
            int a = int'($signed(app_out[n*W +: W]));
            chk(a == e_app[n], {tag, " R4 R5 R6 app value"}, a, e_app[n]);
            chk(int'(bits_out[n]) == e_hard[n], {tag, " R6 hard bit"}, int'(bits_out[n]), e_hard[n]);
        end
        chk(int'(success) == e_ok, {tag, " R7 R8 success"}, int'(success), e_ok);
        chk(int'(iter_count) == e_iter, {tag, " R9 iter_count"}, int'(iter_count), e_iter);
    endtask

    task automatic run_case(input string tag);
        int junk[7];
        model_run();
        if (e_ok == 0) n_fail_runs++;
        if (e_iter > 1) n_multi_runs++;
        for (int n = 0; n < 7; n++) junk[n] = (n % 2 == 0) ? -25 : 19;
        @(negedge clk);
        llr_in = pack(vin);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
        chk(done == 1'b0, {tag, " R9 no done at start"}, int'(done), 0);
        for (int k = 1; k <= e_iter; k++) begin
            if (k == 1 && e_iter >= 2) begin
                llr_in = pack(junk);
                start = 1'b1;   // R2: must be ignored while busy
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (k < e_iter) begin
                chk(busy == 1'b1, {tag, " R9 busy during run"}, int'(busy), 1);
                chk(done == 1'b0, {tag, " R9 done early"}, int'(done), 0);
            end else begin
                chk(busy == 1'b0, {tag, " R9 busy at end"}, int'(busy), 0);
                chk(done == 1'b1, {tag, " R9 done pulse"}, int'(done), 1);
                check_results(tag);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, int'(done), 0);
        chk(busy == 1'b0, {tag, " R2 R9 stays idle"}, int'(busy), 0);
        check_results({tag, " R9 hold"});
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done reset", int'(done), 0);
        chk(success == 1'b0, "R1 success reset", int'(success), 0);
        chk(iter_count == '0, "R1 iter reset", int'(iter_count), 0);
        chk(bits_out == '0, "R1 bits reset", int'(bits_out), 0);
        chk(app_out == '0, "R1 app reset", 0, 0);
        rst_n = 1'b1;

        // R7: strong all-zero codeword
        vin = '{20, 20, 20, 20, 20, 20, 20};
        run_case("zero codeword");
        // R3: codeword with bits 0,2,3 set
        vin = '{-10, 12, -9, -11, 8, 7, 9};
        run_case("R3 codeword 1011000");
        // one weak wrong bit
        vin = '{-10, 12, -9, -11, -3, 7, 9};
        run_case("R5 weak error bit4");
        // two errors on the high-degree bit and a neighbour
        vin = '{-10, -2, -9, -11, 8, 7, -1};
        run_case("R4 two errors");
        // saturation extremes
        vin = '{-32, -32, -32, 31, 31, 31, -32};
        run_case("R6 saturation");
        vin = '{31, 31, 31, 31, 31, 31, 31};
        run_case("R6 positive rail");
        // all zero inputs: zero counts positive
        vin = '{0, 0, 0, 0, 0, 0, 0};
        run_case("R5 zero sign");

        for (int t = 0; t < 60; t++) begin
            for (int n = 0; n < 7; n++) vin[n] = int'($urandom_range(0, 63)) - 32;
            run_case("random");
        end

        chk(n_fail_runs > 0, "R8 limit path reached", n_fail_runs, 1);
        chk(n_multi_runs > 0, "R2 multi-iteration run", n_multi_runs, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule